// File: doc/BRIEF.md
# DMA Transfer Count Unit

This block keeps the transfer count of one DMA channel. A descriptor loader writes a 16-bit count word and a mode code in one strobe. In normal mode the whole word is a single down-counter. When it reaches zero the block raises a one-cycle done pulse and then ignores further transfer strobes until the next load.

In repeat and block modes the word is split into two bytes. The upper byte holds the reload value and the lower byte is the live counter. When the live counter runs out, it refills from the upper byte and the block raises a one-cycle reload pulse. This continues for as long as transfers arrive.

Each transfer strobe comes with a size flag and a 24-bit destination address. A word-sized transfer to an odd address is rejected: it raises an alignment error and does not touch the count.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset, the outputs are as follows: `count_out` is 0, `mode_out` is 0 (normal), `run` is 0, and `done_pulse`, `reload_pulse` and `align_err` are all 0.
- R2: A `load_en` strobe places `load_count` on `count_out` and `load_mode` on `mode_out` on the next cycle, and sets `run`. The mode codes are: 0 normal, 1 repeat, 2 block; any nonzero code selects split counting.
- R3: In normal mode with `run` set, each accepted transfer strobe lowers `count_out` by exactly one, one cycle later.
- R4: In normal mode, the strobe that takes the count from 1 to 0 makes `done_pulse` high for exactly one cycle, together with `count_out` = 0, and clears `run`.
- R5: In normal mode with `run` clear, transfer strobes are ignored: `count_out` stays 0 and no pulse appears.
- R6: In normal mode a loaded count of 0 means 65,536 transfers. The first strobe gives 16'hFFFF with no done pulse and `run` still set.
- R7: In split modes, a strobe lowers bits [7:0] by one and leaves bits [15:8] unchanged.
- R8: In split modes, the strobe that takes bits [7:0] from 1 loads bits [7:0] from bits [15:8] and makes `reload_pulse` high for one cycle.
- R9: In split modes, a live counter of 0 means 256: a strobe gives 8'hFF with no reload pulse.
- R10: When `load_en` and `xfer_strobe` are both high in the same cycle, the load wins and the strobe has no effect on the count.
- R11: A strobe with `xfer_word` = 1 and `dest_addr[0]` = 1 raises `align_err` for one cycle and leaves the count unchanged. Byte transfers to odd addresses and word transfers to even addresses are accepted.
- R12: Repeat mode (code 1) and block mode (code 2) count and reload identically, and `mode_out` reports the loaded code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load strobe for the count word and mode |
| load_count | input | 16 | Count word to load |
| load_mode | input | 2 | Mode code: 0 normal, 1 repeat, 2 block |
| xfer_strobe | input | 1 | One completed transfer |
| xfer_word | input | 1 | 1 = word-size transfer, 0 = byte |
| dest_addr | input | 24 | Destination address of the transfer |
| count_out | output | 16 | Current count word |
| mode_out | output | 2 | Current mode code |
| run | output | 1 | Counting is armed |
| done_pulse | output | 1 | Normal-mode count reached zero |
| reload_pulse | output | 1 | Split-mode live counter reloaded |
| align_err | output | 1 | Word transfer to an odd address was rejected |

## Verification
`count_out` is the count register itself, so any wrong internal count shows at the ports one cycle after the strobe that caused it. A lost or extra decrement therefore shows up at the very next check. A wrong zero or arming decision shows up differently: as a missing or doubled `done_pulse`, as a count that keeps falling past zero, or as an early stop when a zero load should mean 65,536. In split modes, a fault in the reload path shows as `reload_pulse` in the wrong cycle, or as a live byte that differs from the upper byte on the cycle after a reload.

// File: rtl/xcu_pkg.sv
package xcu_pkg;
  typedef enum logic [1:0] {
    XM_WIDE = 2'b00,
    XM_RPT  = 2'b01,
    XM_BLK  = 2'b10,
    XM_RSV  = 2'b11
  } xcu_mode_e;

  function automatic logic xcu_is_split(xcu_mode_e m);
    return m != XM_WIDE;
  endfunction
endpackage

// File: rtl/xcu_wide_step.sv
module xcu_wide_step #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             armed,
  input  logic             go,
  output logic [CNT_W-1:0] nxt,
  output logic             last
);
  // Zero with armed set stands for the full range; wrapping to all ones is correct.
  always_comb begin
    nxt  = cnt - CNT_W'(1);
    last = go && armed && (cnt == CNT_W'(1));
  end
endmodule

// File: rtl/xcu_split_step.sv
module xcu_split_step #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             go,
  output logic [CNT_W-1:0] nxt,
  output logic             reload
);
  localparam int HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] hi_b, lo_b;

  always_comb begin
    hi_b   = cnt[CNT_W-1:HALF_W];
    lo_b   = cnt[HALF_W-1:0];
    reload = go && (lo_b == HALF_W'(1));
    if (reload) nxt = {hi_b, hi_b};
    else        nxt = {hi_b, lo_b - HALF_W'(1)};
  end
endmodule

// File: rtl/xcu_align_chk.sv
module xcu_align_chk #(
  parameter int ADDR_W = 24
) (
  input  logic              strobe,
  input  logic              word,
  input  logic [ADDR_W-1:0] addr,
  output logic              accept,
  output logic              bad
);
  logic unused_hi;
  assign unused_hi = ^addr[ADDR_W-1:1];

  always_comb begin
    bad    = strobe && word && addr[0];
    accept = strobe && !bad;
  end
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
  import xcu_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [CNT_W-1:0]  load_count,
  input  logic [1:0]        load_mode,
  input  logic              xfer_strobe,
  input  logic              xfer_word,
  input  logic [ADDR_W-1:0] dest_addr,
  output logic [CNT_W-1:0]  count_out,
  output logic [1:0]        mode_out,
  output logic              run,
  output logic              done_pulse,
  output logic              reload_pulse,
  output logic              align_err
);
  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, w_nxt, s_nxt;
  xcu_mode_e        mode_q;
  logic             armed_q, done_q, reload_q, err_q;
  logic             accept, bad, w_last, s_reload;
  logic             split;

  assign split = xcu_is_split(mode_q);

  xcu_align_chk #(.ADDR_W(ADDR_W)) u_align (
    .strobe (xfer_strobe),
    .word   (xfer_word),
    .addr   (dest_addr),
    .accept (accept),
    .bad    (bad)
  );

  xcu_wide_step #(.CNT_W(CNT_W)) u_wide (
    .cnt   (cnt_q),
    .armed (armed_q),
    .go    (accept && !split),
    .nxt   (w_nxt),
    .last  (w_last)
  );

  xcu_split_step #(.CNT_W(CNT_W)) u_split (
    .cnt    (cnt_q),
    .go     (accept && split),
    .nxt    (s_nxt),
    .reload (s_reload)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      mode_q   <= XM_WIDE;
      armed_q  <= 1'b0;
      done_q   <= 1'b0;
      reload_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      reload_q <= 1'b0;
      err_q    <= bad;
      if (load_en) begin
        cnt_q   <= load_count;
        mode_q  <= xcu_mode_e'(load_mode);
        armed_q <= 1'b1;
      end else if (accept) begin
        if (split) begin
          cnt_q    <= s_nxt;
          reload_q <= s_reload;
        end else if (armed_q) begin
          cnt_q <= w_nxt;
          if (w_last) begin
            armed_q <= 1'b0;
            done_q  <= 1'b1;
          end
        end
      end
    end
  end

  assign count_out    = cnt_q;
  assign mode_out     = mode_q;
  assign run          = armed_q;
  assign done_pulse   = done_q;
  assign reload_pulse = reload_q;
  assign align_err    = err_q;

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (count_out == $past(load_count)) && run);

  assert_done_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  assert_done_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (count_out == '0) && !run && (mode_out == 2'b00));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_en) |=> $stable(count_out) && !done_pulse);

  assert_reload_value_R8: assert property (@(posedge clk) disable iff (rst)
    reload_pulse |-> count_out[HALF_W-1:0] == count_out[CNT_W-1:HALF_W]);

  assert_align_reject_R11: assert property (@(posedge clk) disable iff (rst)
    (xfer_strobe && xfer_word && dest_addr[0] && !load_en) |=> align_err && $stable(count_out));

  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(done_pulse && reload_pulse));
endmodule

// File: tb/xfer_count_unit_bench.sv
module xfer_count_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [15:0] load_count = '0;
  logic [1:0]  load_mode = '0;
  logic        xfer_strobe = 1'b0;
  logic        xfer_word = 1'b0;
  logic [23:0] dest_addr = '0;
  logic [15:0] count_out;
  logic [1:0]  mode_out;
  logic        run, done_pulse, reload_pulse, align_err;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  xfer_count_unit u_xfer_count_unit (
    .clk(clk), .rst(rst), .load_en(load_en), .load_count(load_count),
    .load_mode(load_mode), .xfer_strobe(xfer_strobe), .xfer_word(xfer_word),
    .dest_addr(dest_addr), .count_out(count_out), .mode_out(mode_out),
    .run(run), .done_pulse(done_pulse), .reload_pulse(reload_pulse),
    .align_err(align_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [15:0] v, logic [1:0] m);
    @(negedge clk);
    load_en = 1'b1; load_count = v; load_mode = m;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic do_step(logic w, logic [23:0] a);
    @(negedge clk);
    xfer_strobe = 1'b1; xfer_word = w; dest_addr = a;
    @(negedge clk);
    xfer_strobe = 1'b0; xfer_word = 1'b0; dest_addr = '0;
  endtask

  task automatic t_reset();
    chk("R1 count", count_out, 0);
    chk("R1 mode", mode_out, 0);
    chk("R1 run", run, 0);
    chk("R1 pulses", {done_pulse, reload_pulse, align_err}, 0);
  endtask

  task automatic t_normal();
    do_load(16'd3, 2'd0);
    chk("R2 count", count_out, 3);
    chk("R2 run", run, 1);
    do_step(1'b0, 24'h0);
    chk("R3 dec", count_out, 2);
    do_step(1'b0, 24'h0);
    chk("R3 dec", count_out, 1);
    chk("R4 no early done", done_pulse, 0);
    do_step(1'b0, 24'h0);
    chk("R4 zero", count_out, 0);
    chk("R4 done", done_pulse, 1);
    chk("R4 run clear", run, 0);
    @(negedge clk);
    chk("R4 done one cycle", done_pulse, 0);
    do_step(1'b0, 24'h0);
    chk("R5 ignored count", count_out, 0);
    chk("R5 ignored pulse", done_pulse, 0);
  endtask

  task automatic t_long();
    do_load(16'd300, 2'd0);
    @(negedge clk);
    xfer_strobe = 1'b1;
    repeat (299) @(negedge clk);
    chk("R3 long count", count_out, 1);
    chk("R4 long no done", done_pulse, 0);
    @(negedge clk);
    xfer_strobe = 1'b0;
    chk("R4 long done", {done_pulse, count_out}, 17'h10000);
  endtask

  task automatic t_zero_wide();
    do_load(16'd0, 2'd0);
    do_step(1'b0, 24'h0);
    chk("R6 wrap", count_out, 16'hFFFF);
    chk("R6 no done", done_pulse, 0);
    chk("R6 run", run, 1);
  endtask

  task automatic t_split();
    do_load(16'h0302, 2'd1);
    chk("R2 mode", mode_out, 1);
    do_step(1'b0, 24'h0);
    chk("R7 low dec", count_out, 16'h0301);
    do_step(1'b0, 24'h0);
    chk("R8 reload value", count_out, 16'h0303);
    chk("R8 reload pulse", reload_pulse, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", reload_pulse, 0);
    do_step(1'b0, 24'h0);
    chk("R7 after reload", count_out, 16'h0302);
    do_load(16'h0400, 2'd1);
    do_step(1'b0, 24'h0);
    chk("R9 low zero", count_out, 16'h04FF);
    chk("R9 no pulse", reload_pulse, 0);
  endtask

  task automatic t_block();
    do_load(16'h0502, 2'd2);
    chk("R12 mode", mode_out, 2);
    do_step(1'b0, 24'h0);
    chk("R12 dec", count_out, 16'h0501);
    do_step(1'b0, 24'h0);
    chk("R12 reload", {reload_pulse, count_out}, 17'h10505);
  endtask

  task automatic t_prio();
    do_load(16'd9, 2'd0);
    @(negedge clk);
    load_en = 1'b1; load_count = 16'd5; load_mode = 2'd0; xfer_strobe = 1'b1;
    @(negedge clk);
    load_en = 1'b0; xfer_strobe = 1'b0;
    chk("R10 load wins", count_out, 5);
    chk("R10 run", run, 1);
  endtask

  task automatic t_align();
    do_load(16'd10, 2'd0);
    do_step(1'b1, 24'h000101);
    chk("R11 err", align_err, 1);
    chk("R11 count held", count_out, 10);
    @(negedge clk);
    chk("R11 err one cycle", align_err, 0);
    do_step(1'b0, 24'h000101);
    chk("R11 byte odd ok", {align_err, count_out}, 17'd9);
    do_step(1'b1, 24'h000100);
    chk("R11 word even ok", {align_err, count_out}, 17'd8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_long();
    t_zero_wide();
    t_split();
    t_block();
    t_prio();
    t_align();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule